// File: doc/BRIEF.md
# Neural Crossbar Matching Scheduler

This block picks which packets cross an N-by-N input-queued crossbar in one switch cycle. The caller presents a request matrix and pulses `start`. Bit `i*N+j` of `req` set means input `i` holds a packet for output `j`. The block answers with a single-cycle `done` pulse and a grant matrix in the same bit layout. The grant closes at most one crosspoint per input row and per output column.

Inside, every crosspoint owns a one-bit neuron, so there are N² neurons. When a run begins, each requested neuron is switched on and every other neuron is clamped off. Rows are then revisited one per clock in a fixed cyclic order.

A neuron's activation is a bias minus a fixed inhibition weight times the number of active neurons that share its row or column. A pseudo-random tie-break bit may also be added. A digital threshold then gives the neuron's new value. A neuron that is already on gets a slightly larger bias than one that is off. Within the row being revisited, at most one off neuron may switch on, and it is the lowest-numbered eligible one.

A run ends in one of two ways. It ends when a full sweep changes nothing and no row or column holds two active neurons. Otherwise it ends after 4·N sweeps. A final cleanup stage keeps only the lowest-indexed active neuron in each row and then in each column, so the published grant is always legal.

Top module: `xbar_nn_sched`

## Requirements
- R1: After reset, and until the first run finishes, `done` is 0 and `grant` is all zeros.
- R2: A grant bit is never set where the latched request bit is 0. The bit layout is index `i*N+j` for input `i` and output `j`.
- R3: With `done` high, each row `i` (bits `i*N .. i*N+N-1`) holds at most one set bit. Each column `j` (bits `j, j+N, j+2N, ...`) also holds at most one set bit.
- R4: Each accepted `start` produces exactly one `done`, and `done` is high for exactly one cycle. No further `done` appears without a new `start`.
- R5: A `start` that arrives while a run is in progress is ignored. The request it carries does not affect the grant of the current run, and it starts no run of its own.
- R6: When the network settles within the sweep limit, the grant is maximal. For every requested crosspoint, its row or its column holds a granted bit.
- R7: For the requests (1,1), (1,3) and (3,1), written as (input,output), the grant is (1,3) and (3,1). This is two packets, not (1,1) alone.
- R8: A request matrix that has no two bits in one row or one column is granted unchanged. An all-zero request is granted as all zeros.
- R9: `done` rises no later than 4·N·N + 2 cycles after the edge that accepts `start`.
- R10: When every crosspoint is requested, exactly N crosspoints are granted.
- R11: A `start` presented in the same cycle that `done` is high is accepted and begins a new run on the newly presented request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run on `req`; ignored while a run is in progress |
| req | input | N*N | Request matrix, bit `i*N+j` = input `i` wants output `j` |
| done | output | 1 | One-cycle pulse when `grant` holds a new result |
| grant | output | N*N | Legal grant matrix, same layout as `req`; held until the next result |

## Verification
The cycle that publishes a result is the same cycle in which the idle scheduler can accept its next request. A new `start` can therefore collide with `done`. The bench provokes this by raising `start` with a different request in the exact cycle it sees `done`. It then judges that a second `done` follows and that the second grant matches the new request, not the old one. The opposite overlap, a `start` that lands mid-run, is also provoked. There the result must still belong to the first request, and only one `done` may follow.

// File: rtl/xbar_nn_pkg.sv
// Shared types and constants for the neural crossbar scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package xbar_nn_pkg;

    // Controller phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_t;

    // Neuron weights: activation = bias - W_INH * active_peers (+ tie bit)
    localparam int BIAS_ON  = 2;
    localparam int BIAS_OFF = 1;
    localparam int W_INH    = 2;

    // Width of the tie-break shift register
    localparam int TIE_W = 16;

endpackage

// File: rtl/nn_tie_lfsr.sv
// Free-running Galois LFSR that supplies one tie-break bit per column.
// Assumes: SEED is non-zero; columns beyond TIE_W reuse bits modulo TIE_W.
module nn_tie_lfsr
    import xbar_nn_pkg::*;
#(
    parameter int N = 16,
    parameter logic [TIE_W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] tie
);

    logic [TIE_W-1:0] sr;

    // Advance the register every clock (taps 16,14,13,11)
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= SEED;
        else        sr <= {1'b0, sr[TIE_W-1:1]} ^ (sr[0] ? 16'hB400 : 16'h0000);
    end

    generate
        for (genvar j = 0; j < N; j++) begin : g_tap
            assign tie[j] = sr[j % TIE_W];
        end
    endgenerate

    assert_seed_live_R6: assert property (@(posedge clk) disable iff (!rst_n) sr != '0);

endmodule

// File: rtl/nn_row_update.sv
// Computes the next value of every neuron in one selected row.
// Each neuron counts active peers in its row and column (itself excluded),
// forms a thresholded activation, and at most one off neuron (the lowest
// eligible) may switch on. Unrequested neurons are forced off.
// Assumes: row_i < N.
module nn_row_update
    import xbar_nn_pkg::*;
#(
    parameter int N  = 16,
    localparam int NN = N * N,
    localparam int RW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [NN-1:0] state_i,
    input  logic [N-1:0]  req_row_i,
    input  logic [RW-1:0] row_i,
    input  logic [N-1:0]  tie_i,
    output logic [N-1:0]  row_o,
    output logic          chg_o
);

    logic [N-1:0] cur;

    // Current contents of the selected row
    always_comb cur = state_i[int'(row_i)*N +: N];

    // Activation and threshold for each neuron of the row
    always_comb begin
        int rc;
        int cc;
        int peers;
        int act;
        logic joined;
        rc = 0;
        joined = 1'b0;
        row_o = '0;
        for (int j = 0; j < N; j++) rc += int'(cur[j]);
        for (int j = 0; j < N; j++) begin
            cc = 0;
            for (int i = 0; i < N; i++) cc += int'(state_i[i*N+j]);
            peers = (rc - int'(cur[j])) + (cc - int'(cur[j]));
            if (cur[j]) begin
                act = BIAS_ON - W_INH * peers + int'(tie_i[j]);
                row_o[j] = req_row_i[j] && (act > 0);
            end else begin
                act = BIAS_OFF - W_INH * peers;
                if (req_row_i[j] && (act > 0) && !joined) begin
                    row_o[j] = 1'b1;
                    joined = 1'b1;
                end
            end
        end
    end

    assign chg_o = (row_o != cur);

endmodule

// File: rtl/nn_legalize.sv
// Final cleanup: keeps the lowest-column active bit per row, then the
// lowest-row bit per column; also flags any row or column conflict.
// Assumes: flat layout, bit i*N+j.
module nn_legalize #(
    parameter int N  = 16,
    localparam int NN = N * N
) (
    input  logic [NN-1:0] st_i,
    output logic [NN-1:0] legal_o,
    output logic          conflict_o
);

    logic [NN-1:0] rowkept;

    // Row pass then column pass, lowest index wins
    always_comb begin
        logic found;
        rowkept = '0;
        legal_o = '0;
        for (int i = 0; i < N; i++) begin
            found = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (st_i[i*N+j] && !found) begin
                    rowkept[i*N+j] = 1'b1;
                    found = 1'b1;
                end
            end
        end
        for (int j = 0; j < N; j++) begin
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (rowkept[i*N+j] && !found) begin
                    legal_o[i*N+j] = 1'b1;
                    found = 1'b1;
                end
            end
        end
    end

    // Detect more than one active bit in any row or column
    always_comb begin
        int rc;
        int cc;
        conflict_o = 1'b0;
        for (int a = 0; a < N; a++) begin
            rc = 0;
            cc = 0;
            for (int b = 0; b < N; b++) begin
                rc += int'(st_i[a*N+b]);
                cc += int'(st_i[b*N+a]);
            end
            if (rc > 1 || cc > 1) conflict_o = 1'b1;
        end
    end

endmodule

// File: rtl/xbar_nn_sched.sv
// Neural crossbar matching scheduler, top level.
// Loads the request into the neuron array, revisits one row per clock until
// a sweep is quiet and conflict-free or the sweep limit is hit, then
// publishes a legalised grant with a one-cycle done pulse.
// Assumes: start is ignored outside the idle phase; N >= 2.
module xbar_nn_sched
    import xbar_nn_pkg::*;
#(
    parameter int N = 16,
    parameter logic [TIE_W-1:0] TIE_SEED = 16'hACE1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*N-1:0] req,
    output logic           done,
    output logic [N*N-1:0] grant
);

    localparam int NN      = N * N;
    localparam int RW      = (N > 1) ? $clog2(N) : 1;
    localparam int SWEEPS  = 4 * N;
    localparam int SW      = $clog2(SWEEPS + 1);
    localparam int MAX_LAT = SWEEPS * N + 1;

    phase_t        phase;
    logic [NN-1:0] req_q;
    logic [NN-1:0] state;
    logic [RW-1:0] row;
    logic [SW-1:0] sweep;
    logic          dirty;
    logic [N-1:0]  tie;
    logic [N-1:0]  row_new;
    logic          row_chg;
    logic [NN-1:0] legal;
    logic          conflict;
    logic          last_row;
    logic          quiet;
    logic          limit;

    nn_tie_lfsr #(.N(N), .SEED(TIE_SEED)) u_tie (
        .clk   (clk),
        .rst_n (rst_n),
        .tie   (tie)
    );

    nn_row_update #(.N(N)) u_row (
        .state_i   (state),
        .req_row_i (req_q[int'(row)*N +: N]),
        .row_i     (row),
        .tie_i     (tie),
        .row_o     (row_new),
        .chg_o     (row_chg)
    );

    nn_legalize #(.N(N)) u_legal (
        .st_i       (state),
        .legal_o    (legal),
        .conflict_o (conflict)
    );

    // End-of-sweep decisions
    assign last_row = (row == RW'(N - 1));
    assign quiet    = !dirty && !row_chg && !conflict;
    assign limit    = (sweep == SW'(SWEEPS - 1));

    // Phase sequencing, neuron array update and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            req_q <= '0;
            state <= '0;
            row   <= '0;
            sweep <= '0;
            dirty <= 1'b0;
            done  <= 1'b0;
            grant <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        req_q <= req;
                        state <= req;
                        row   <= '0;
                        sweep <= '0;
                        dirty <= 1'b0;
                        phase <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    state[int'(row)*N +: N] <= row_new;
                    if (last_row) begin
                        row   <= '0;
                        dirty <= 1'b0;
                        sweep <= sweep + 1'b1;
                        if (quiet || limit) phase <= PH_FIN;
                    end else begin
                        row   <= row + 1'b1;
                        dirty <= dirty | row_chg;
                    end
                end
                default: begin
                    grant <= legal;
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Checker state: cycles since the accepted start
    int busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                            busy_cnt <= 0;
        else if (phase == PH_IDLE && start)    busy_cnt <= 0;
        else if (phase != PH_IDLE)             busy_cnt <= busy_cnt + 1;
    end

    assert_state_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state & ~req_q) == '0);
    assert_grant_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant & ~req_q) == '0);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && start) |=> $stable(req_q));
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= MAX_LAT);

    generate
        for (genvar k = 0; k < N; k++) begin : g_legal_chk
            logic [N-1:0] col_bits;
            for (genvar m = 0; m < N; m++) begin : g_col
                assign col_bits[m] = grant[m*N+k];
            end
            assert_row_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> $onehot0(grant[k*N +: N]));
            assert_col_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> $onehot0(col_bits));
        end
    endgenerate

endmodule

// File: tb/tb_xbar_nn_sched.sv
`timescale 1ns/1ps
module tb_xbar_nn_sched;

    localparam int TN  = 4;
    localparam int TNN = TN * TN;
    localparam int MAX_WAIT = 4 * TN * TN + 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [TNN-1:0] req = '0;
    logic           done;
    logic [TNN-1:0] grant;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    xbar_nn_sched #(.N(TN)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .req   (req),
        .done  (done),
        .grant (grant)
    );

    // {request, expected grant, exact-match flag}
    localparam logic [32:0] VEC [8] = '{
        {16'h0000, 16'h0000, 1'b1},   // R8 empty
        {16'h20A0, 16'h2080, 1'b1},   // R7 three-way conflict
        {16'h8421, 16'h8421, 1'b1},   // R8 identity
        {16'h1248, 16'h1248, 1'b1},   // R8 anti-diagonal
        {16'hFFFF, 16'h0000, 1'b0},   // R10 full
        {16'h000F, 16'h0000, 1'b0},   // one row
        {16'h4444, 16'h0000, 1'b0},   // one column
        {16'h0063, 16'h0000, 1'b0}    // chain
    };

    task automatic chk(input bit ok, input string tag, input logic [TNN-1:0] act,
                       input logic [TNN-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_legal(input logic [TNN-1:0] g);
        for (int a = 0; a < TN; a++) begin
            int rc = 0;
            int cc = 0;
            for (int b = 0; b < TN; b++) begin
                rc += int'(g[a*TN+b]);
                cc += int'(g[b*TN+a]);
            end
            if (rc > 1 || cc > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit is_maximal(input logic [TNN-1:0] r, input logic [TNN-1:0] g);
        for (int i = 0; i < TN; i++) begin
            for (int j = 0; j < TN; j++) begin
                if (r[i*TN+j]) begin
                    bit used = 1'b0;
                    for (int k = 0; k < TN; k++)
                        if (g[i*TN+k] || g[k*TN+j]) used = 1'b1;
                    if (!used) return 1'b0;
                end
            end
        end
        return 1'b1;
    endfunction

    // Wait at falling edges for done; returns 1 if seen
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < MAX_WAIT; c++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic kick(input logic [TNN-1:0] r);
        @(negedge clk);
        start = 1'b1;
        req   = r;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic judge(input logic [TNN-1:0] r, input logic [TNN-1:0] e, input bit exact);
        chk((grant & ~r) == '0, "R2 grant outside request", grant, r);
        chk(is_legal(grant), "R3 row/column exclusivity", grant, e);
        chk(is_maximal(r, grant), "R6 maximal grant", grant, r);
        if (exact) chk(grant == e, "R7/R8 exact grant", grant, e);
        if (r == '1) chk($countones(grant) == TN, "R10 full request count", grant, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done after reset", TNN'(done), '0);
        chk(grant == '0, "R1 grant after reset", grant, '0);

        // Table of vectors
        for (int v = 0; v < 8; v++) begin
            logic [TNN-1:0] r;
            logic [TNN-1:0] e;
            bit x;
            r = VEC[v][32:17];
            e = VEC[v][16:1];
            x = VEC[v][0];
            kick(r);
            wait_done(seen);
            chk(seen, "R9 done within bound", TNN'(seen), TNN'(1));
            judge(r, e, x);
            @(negedge clk);
            chk(done == 1'b0, "R4 done one cycle", TNN'(done), '0);
        end

        // R4: no done without a new start
        begin
            bit extra = 1'b0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
            end
            chk(!extra, "R4 no spurious done", TNN'(extra), '0);
        end

        // R5: start mid-run is ignored
        kick(16'h20A0);
        repeat (2) @(negedge clk);
        start = 1'b1;
        req   = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen, "R5 first run completes", TNN'(seen), TNN'(1));
        chk(grant == 16'h2080, "R5 grant from first request", grant, 16'h2080);
        begin
            bit extra = 1'b0;
            for (int c = 0; c < MAX_WAIT; c++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
            end
            chk(!extra, "R5 mid-run start started no run", TNN'(extra), '0);
        end

        // R11: start presented in the done cycle
        kick(16'h1248);
        wait_done(seen);
        chk(seen && grant == 16'h1248, "R11 first of back-to-back", grant, 16'h1248);
        start = 1'b1;
        req   = 16'h8421;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen, "R11 second done arrives", TNN'(seen), TNN'(1));
        chk(grant == 16'h8421, "R11 second grant from new request", grant, 16'h8421);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule